// File: doc/BRIEF.md
# EEPROM Write Protection Controller

This block owns the protection state of a serial EEPROM and rules on every write that the command decoder hands it. It keeps the status byte: a hardware-lock enable, a two-bit guard field that picks which part of the array is read-only, the write-enable latch and a busy flag. The command decoder passes in one-cycle requests while chip select is low. The block accepts or refuses each request at once. An accepted write stays pending until chip select rises, and at that point the self-timed write cycle starts.

The write-protect pin only has an effect when the lock-enable bit is set. While it is active, status writes are refused. A status write that is already pending is cancelled if the pin falls before chip select rises. After the write cycle has begun, the pin no longer matters. Array writes are checked against the guard field using the start address. A page never crosses a guarded boundary, so the start address decides for the whole page. The write-cycle length is a parameter in clock cycles.

Top module: `wpc_write_guard`

## Requirements
- R1: After reset the status byte is 0x00: lock enable 0, guard 00, latch 0, busy 0.
- R2: A set-enable request with chip select low and no cycle running sets the latch (status bit 1). A clear-enable request clears it. While busy, both requests leave the latch unchanged.
- R3: A status write accepted with chip select low is committed on the next chip-select rise. Commit raises a one-cycle `sr_grant`. Data bit 7 goes to lock enable and data bits 3:2 go to the guard field. The other data bits are ignored, so status bits 6:4 stay 0.
- R4: When lock enable (status bit 7) is 1 and `wp_n` is low, a status write request is refused with a one-cycle `deny`. When lock enable is 0, `wp_n` has no effect on status writes.
- R5: A pending status write is cancelled if `wp_n` falls while chip select is still low and lock enable is 1. Cancellation gives `deny`, no grant, and an unchanged status byte. A `wp_n` fall in the cycle chip select rises, or later, does not stop the write.
- R6: An array write is refused with `deny` when its address is guarded. Guard 00 protects nothing. 01 protects addresses with both top bits 1 (0xC000 and up at 16 bits). 10 protects addresses with the top bit 1. 11 protects all addresses. Any other address is accepted and raises `arr_grant` on the chip-select rise.
- R7: Status and array write requests are refused with `deny` while the latch is 0.
- R8: A grant starts a write cycle. Status bit 0 is 1 for exactly CYCLE_LEN cycles, starting with the grant cycle. Every status or array write request made while busy is refused with `deny`.
- R9: The latch clears in the cycle the busy flag falls.
- R10: Requests made while chip select is high are ignored, and no grant or deny follows.
- R11: A second write request while one is pending is refused with `deny`. `arr_grant`, `sr_grant` and `deny` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select level, low = selected |
| wp_n | input | 1 | Write-protect pin, low = protect |
| wren_req | input | 1 | Set-enable request pulse |
| wrdi_req | input | 1 | Clear-enable request pulse |
| wrsr_req | input | 1 | Status write request pulse |
| wrsr_data | input | 8 | Status write data |
| arr_req | input | 1 | Array write request pulse |
| arr_addr | input | ADDR_W | Array write start address |
| arr_grant | output | 1 | Array write cycle started |
| sr_grant | output | 1 | Status write committed and cycle started |
| deny | output | 1 | Request refused or pending status write cancelled |
| status | output | 8 | Status byte {lock_en,000,guard,latch,busy} |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Write cycle running |

## Verification
The assertions assume the decoder raises at most one request per cycle and raises requests only while chip select is low. Chip select and the write-protect pin are assumed to be synchronous levels that change between clock edges. The stimulus follows these rules. Each chip-select frame carries one command, and inputs change only at the falling clock edge. The one deliberate exception is a request driven with chip select high, which exercises R10.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int SR_W        = 8;
    localparam int SR_BUSY_BIT = 0;
    localparam int SR_WEL_BIT  = 1;
    localparam int SR_GRD_LSB  = 2;
    localparam int SR_LOCK_BIT = 7;

    typedef enum logic [1:0] {
        GUARD_NONE    = 2'b00,
        GUARD_QUARTER = 2'b01,
        GUARD_HALF    = 2'b10,
        GUARD_ALL     = 2'b11
    } guard_e;

    typedef struct packed {
        logic   lock_en;
        guard_e guard;
    } prot_cfg_t;

    typedef enum logic [1:0] {
        PEND_IDLE   = 2'b00,
        PEND_STATUS = 2'b01,
        PEND_ARRAY  = 2'b10
    } pend_e;

    function automatic prot_cfg_t cfg_from_byte(input logic [SR_W-1:0] d);
        prot_cfg_t c;
        c.lock_en = d[SR_LOCK_BIT];
        c.guard   = guard_e'(d[SR_GRD_LSB +: 2]);
        return c;
    endfunction

    function automatic logic [SR_W-1:0] status_byte(input prot_cfg_t c,
                                                    input logic wel_v,
                                                    input logic busy_v);
        logic [SR_W-1:0] b;
        b                  = '0;
        b[SR_LOCK_BIT]     = c.lock_en;
        b[SR_GRD_LSB +: 2] = c.guard;
        b[SR_WEL_BIT]      = wel_v;
        b[SR_BUSY_BIT]     = busy_v;
        return b;
    endfunction

endpackage

// File: rtl/wpc_gate.sv
module wpc_gate
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  prot_cfg_t         cfg,
    input  logic              wel_v,
    input  logic              busy_v,
    input  logic              pend_any,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              lock_active,
    output logic              sr_ok,
    output logic              arr_ok
);
    localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);

    logic guarded;
    logic can_write;

    always_comb begin
        case (cfg.guard)
            GUARD_NONE:    guarded = 1'b0;
            GUARD_QUARTER: guarded = (addr >= QTR_BASE);
            GUARD_HALF:    guarded = (addr >= HALF_BASE);
            default:       guarded = 1'b1;
        endcase
    end

    assign lock_active = cfg.lock_en & ~wp_n;
    assign can_write   = wel_v & ~busy_v & ~pend_any;
    assign sr_ok       = can_write & ~lock_active;
    assign arr_ok      = can_write & ~guarded;
endmodule

// File: rtl/wpc_cycle_timer.sv
module wpc_cycle_timer #(
    parameter int CYCLE_LEN = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLE_LEN + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLE_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= LOAD;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/wpc_write_guard.sv
module wpc_write_guard
    import wpc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CYCLE_LEN = 50000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              wren_req,
    input  logic              wrdi_req,
    input  logic              wrsr_req,
    input  logic [7:0]        wrsr_data,
    input  logic              arr_req,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic              arr_grant,
    output logic              sr_grant,
    output logic              deny,
    output logic [7:0]        status,
    output logic              wel,
    output logic              busy
);
    prot_cfg_t cfg_q;
    prot_cfg_t shadow_q;
    pend_e     pend_q;
    logic      wel_q;
    logic      cs_q;
    logic      arr_grant_q, sr_grant_q, deny_q;
    logic      timer_busy, timer_done;
    logic      lock_active, sr_ok, arr_ok;
    logic      cs_rise, cancel, start_cycle;
    logic      unused_data_bits;

    assign unused_data_bits = ^{wrsr_data[6:4], wrsr_data[1:0]};

    assign cs_rise     = cs_n & ~cs_q;
    assign cancel      = (pend_q == PEND_STATUS) && !cs_n && lock_active;
    assign start_cycle = cs_rise && (pend_q != PEND_IDLE);

    wpc_gate #(.ADDR_W(ADDR_W)) u_gate (
        .cfg         (cfg_q),
        .wel_v       (wel_q),
        .busy_v      (timer_busy),
        .pend_any    (pend_q != PEND_IDLE),
        .wp_n        (wp_n),
        .addr        (arr_addr),
        .lock_active (lock_active),
        .sr_ok       (sr_ok),
        .arr_ok      (arr_ok)
    );

    wpc_cycle_timer #(.CYCLE_LEN(CYCLE_LEN)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start_cycle),
        .busy  (timer_busy),
        .done  (timer_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q       <= '0;
            shadow_q    <= '0;
            pend_q      <= PEND_IDLE;
            wel_q       <= 1'b0;
            cs_q        <= 1'b1;
            arr_grant_q <= 1'b0;
            sr_grant_q  <= 1'b0;
            deny_q      <= 1'b0;
        end else begin
            cs_q        <= cs_n;
            arr_grant_q <= 1'b0;
            sr_grant_q  <= 1'b0;
            deny_q      <= 1'b0;
            if (timer_done) begin
                wel_q <= 1'b0;
            end
            if (cancel) begin
                pend_q <= PEND_IDLE;
                deny_q <= 1'b1;
            end else if (start_cycle) begin
                pend_q <= PEND_IDLE;
                if (pend_q == PEND_STATUS) begin
                    cfg_q      <= shadow_q;
                    sr_grant_q <= 1'b1;
                end else begin
                    arr_grant_q <= 1'b1;
                end
            end else if (!cs_n) begin
                if (wrsr_req) begin
                    if (sr_ok) begin
                        pend_q   <= PEND_STATUS;
                        shadow_q <= cfg_from_byte(wrsr_data);
                    end else begin
                        deny_q <= 1'b1;
                    end
                end else if (arr_req) begin
                    if (arr_ok) begin
                        pend_q <= PEND_ARRAY;
                    end else begin
                        deny_q <= 1'b1;
                    end
                end else if (wren_req && !timer_busy) begin
                    wel_q <= 1'b1;
                end else if (wrdi_req && !timer_busy) begin
                    wel_q <= 1'b0;
                end
            end
        end
    end

    assign arr_grant = arr_grant_q;
    assign sr_grant  = sr_grant_q;
    assign deny      = deny_q;
    assign wel       = wel_q;
    assign busy      = timer_busy;
    assign status    = status_byte(cfg_q, wel_q, timer_busy);
endmodule

// File: rtl/wpc_write_guard_chk.sv
module wpc_write_guard_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic wp_n,
    input logic wrsr_req,
    input logic arr_req,
    input logic arr_grant,
    input logic sr_grant,
    input logic deny,
    input logic lock_bit,
    input logic wel,
    input logic busy
);
    p_one_outcome_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({arr_grant, sr_grant, deny}));

    p_grant_starts_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        (arr_grant || sr_grant) |-> busy);

    p_grant_needs_latch_r7: assert property (@(posedge clk) disable iff (rst)
        (arr_grant || sr_grant) |-> wel);

    p_latch_clears_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    p_busy_refuses_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !cs_n && (wrsr_req || arr_req)) |=> deny);

    p_pin_lock_r4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && wrsr_req && lock_bit && !wp_n) |=> (deny && !sr_grant));

    p_deselected_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |=> !(arr_grant || sr_grant || deny));
endmodule

bind wpc_write_guard wpc_write_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .wp_n      (wp_n),
    .wrsr_req  (wrsr_req),
    .arr_req   (arr_req),
    .arr_grant (arr_grant),
    .sr_grant  (sr_grant),
    .deny      (deny),
    .lock_bit  (status[7]),
    .wel       (wel),
    .busy      (busy)
);

// File: tb/wpc_write_guard_test.sv
module wpc_write_guard_test;
    localparam int CLK_P  = 10;
    localparam int CYC    = 6;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cs_n = 1'b1, wp_n = 1'b1;
    logic              wren_req = 1'b0, wrdi_req = 1'b0, wrsr_req = 1'b0, arr_req = 1'b0;
    logic [7:0]        wrsr_data = '0;
    logic [ADDR_W-1:0] arr_addr = '0;
    logic              arr_grant, sr_grant, deny, wel, busy;
    logic [7:0]        status;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    typedef struct {
        string      tag;
        bit         chk;
        logic [7:0] st;
        logic [2:0] pl;
    } exp_t;
    exp_t q[$];

    always #(CLK_P/2) clk = ~clk;

    wpc_write_guard #(.ADDR_W(ADDR_W), .CYCLE_LEN(CYC)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n),
        .wren_req(wren_req), .wrdi_req(wrdi_req), .wrsr_req(wrsr_req),
        .wrsr_data(wrsr_data), .arr_req(arr_req), .arr_addr(arr_addr),
        .arr_grant(arr_grant), .sr_grant(sr_grant), .deny(deny),
        .status(status), .wel(wel), .busy(busy)
    );

    // pulses are {arr_grant, sr_grant, deny}
    task automatic cyc(input string tag, input bit chk, input logic [7:0] st,
                       input logic [2:0] pl);
        exp_t e;
        e.tag = tag; e.chk = chk; e.st = st; e.pl = pl;
        q.push_back(e);
        @(negedge clk);
        wren_req = 1'b0; wrdi_req = 1'b0; wrsr_req = 1'b0; arr_req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc("idle", 1'b0, 8'h00, 3'b000);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                e = q.pop_front();
                if (e.chk) begin
                    checks++;
                    if (status !== e.st || {arr_grant, sr_grant, deny} !== e.pl
                        || wel !== e.st[1] || busy !== e.st[0]) begin
                        errors++;
                        $display("FAIL %s: status=%h pulses=%b expected status=%h pulses=%b",
                                 e.tag, status, {arr_grant, sr_grant, deny}, e.st, e.pl);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc("R1 reset state", 1, 8'h00, 3'b000);

        // R10: request while deselected
        cs_n = 1'b1; wren_req = 1'b1;
        cyc("R10 deselected set-enable", 1, 8'h00, 3'b000);

        // R2: set then clear the latch
        cs_n = 1'b0; wren_req = 1'b1; cyc("R2 set-enable", 1, 8'h02, 3'b000);
        cs_n = 1'b1; cyc("R2 frame end", 1, 8'h02, 3'b000);
        cs_n = 1'b0; wrdi_req = 1'b1; cyc("R2 clear-enable", 1, 8'h00, 3'b000);
        cs_n = 1'b1; cyc("idle", 0, 8'h00, 3'b000);

        // R7: array write without latch
        cs_n = 1'b0; arr_req = 1'b1; arr_addr = 16'h0000;
        cyc("R7 write with latch clear", 1, 8'h00, 3'b001);
        cs_n = 1'b1; cyc("idle", 0, 8'h00, 3'b000);

        // R3: status write of 0xFF -> lock=1 guard=11
        cs_n = 1'b0; wren_req = 1'b1; cyc("R2 set-enable", 1, 8'h02, 3'b000);
        cs_n = 1'b1; cyc("idle", 0, 8'h00, 3'b000);
        cs_n = 1'b0; wrsr_req = 1'b1; wrsr_data = 8'hFF;
        cyc("R3 status write pending", 1, 8'h02, 3'b000);
        cs_n = 1'b1; cyc("R3 commit on select rise", 1, 8'h8F, 3'b010);

        // R8: refused while busy; R2: clear-enable ignored while busy
        cs_n = 1'b0; wrdi_req = 1'b1; cyc("R2 clear-enable ignored while busy", 1, 8'h8F, 3'b000);
        arr_req = 1'b1; arr_addr = 16'h0000; cyc("R8 array write while busy", 1, 8'h8F, 3'b001);
        wrsr_req = 1'b1; wrsr_data = 8'h00; cyc("R8 status write while busy", 1, 8'h8F, 3'b001);
        cs_n = 1'b1; cyc("R8 still busy", 1, 8'h8F, 3'b000);
        cyc("R8 last busy cycle", 1, 8'h8F, 3'b000);
        cyc("R9 latch clears at cycle end", 1, 8'h8C, 3'b000);

        // R6: guard 11 blocks everything
        cs_n = 1'b0; wren_req = 1'b1; cyc("R2 set-enable", 1, 8'h8E, 3'b000);
        cs_n = 1'b1; cyc("idle", 0, 8'h00, 3'b000);
        cs_n = 1'b0; arr_req = 1'b1; arr_addr = 16'h0000;
        cyc("R6 whole array guarded", 1, 8'h8E, 3'b001);
        cs_n = 1'b1; cyc("idle", 0, 8'h00, 3'b000);

        // R4: pin low with lock enabled
        wp_n = 1'b0; cs_n = 1'b0; wrsr_req = 1'b1; wrsr_data = 8'h00;
        cyc("R4 pin lock refuses status write", 1, 8'h8E, 3'b001);
        cs_n = 1'b1; cyc("idle", 0, 8'h00, 3'b000);

        // R5: pin falls during pending status write
        wp_n = 1'b1; cs_n = 1'b0; wrsr_req = 1'b1; wrsr_data = 8'h00;
        cyc("R5 status write pending", 1, 8'h8E, 3'b000);
        wp_n = 1'b0; cyc("R5 cancel on pin fall", 1, 8'h8E, 3'b001);
        cs_n = 1'b1; cyc("R5 no grant after cancel", 1, 8'h8E, 3'b000);

        // R5: pin falls with the select rise -> write proceeds
        wp_n = 1'b1; cs_n = 1'b0; wrsr_req = 1'b1; wrsr_data = 8'h08;
        cyc("R5 status write pending", 1, 8'h8E, 3'b000);
        cs_n = 1'b1; wp_n = 1'b0;
        cyc("R5 pin fall at select rise ignored", 1, 8'h0B, 3'b010);
        idle(CYC - 1);
        cyc("R9 latch clears", 1, 8'h08, 3'b000);

        // R4: lock disabled, pin low has no effect (pin still low)
        cs_n = 1'b0; wren_req = 1'b1; cyc("R2 set-enable", 1, 8'h0A, 3'b000);
        cs_n = 1'b1; cyc("idle", 0, 8'h00, 3'b000);
        cs_n = 1'b0; wrsr_req = 1'b1; wrsr_data = 8'h04;
        cyc("R4 pin ignored when lock off", 1, 8'h0A, 3'b000);
        cs_n = 1'b1; cyc("R4 commit guard quarter", 1, 8'h07, 3'b010);
        idle(CYC - 1);
        cyc("R9 latch clears", 1, 8'h04, 3'b000);

        // R6 quarter, R11 second request while pending
        wp_n = 1'b1;
        cs_n = 1'b0; wren_req = 1'b1; cyc("R2 set-enable", 1, 8'h06, 3'b000);
        cs_n = 1'b1; cyc("idle", 0, 8'h00, 3'b000);
        cs_n = 1'b0; arr_req = 1'b1; arr_addr = 16'hBFFF;
        cyc("R6 below quarter accepted", 1, 8'h06, 3'b000);
        arr_req = 1'b1; arr_addr = 16'h0000;
        cyc("R11 second request while pending", 1, 8'h06, 3'b001);
        cs_n = 1'b1; cyc("R6 array grant", 1, 8'h07, 3'b100);
        idle(CYC - 1);
        cyc("R9 latch clears", 1, 8'h04, 3'b000);
        cs_n = 1'b0; wren_req = 1'b1; cyc("R2 set-enable", 1, 8'h06, 3'b000);
        cs_n = 1'b1; cyc("idle", 0, 8'h00, 3'b000);
        cs_n = 1'b0; arr_req = 1'b1; arr_addr = 16'hC000;
        cyc("R6 quarter boundary guarded", 1, 8'h06, 3'b001);
        cs_n = 1'b1; cyc("R6 latch kept after refusal", 1, 8'h06, 3'b000);

        // R6 half guard
        cs_n = 1'b0; wrsr_req = 1'b1; wrsr_data = 8'h08;
        cyc("R3 status write pending", 1, 8'h06, 3'b000);
        cs_n = 1'b1; cyc("R3 commit guard half", 1, 8'h0B, 3'b010);
        idle(CYC - 1);
        cyc("R9 latch clears", 1, 8'h08, 3'b000);
        cs_n = 1'b0; wren_req = 1'b1; cyc("R2 set-enable", 1, 8'h0A, 3'b000);
        cs_n = 1'b1; cyc("idle", 0, 8'h00, 3'b000);
        cs_n = 1'b0; arr_req = 1'b1; arr_addr = 16'h8000;
        cyc("R6 half boundary guarded", 1, 8'h0A, 3'b001);
        cs_n = 1'b1; cyc("idle", 0, 8'h00, 3'b000);
        cs_n = 1'b0; arr_req = 1'b1; arr_addr = 16'h7FFF;
        cyc("R6 below half accepted", 1, 8'h0A, 3'b000);
        cs_n = 1'b1; cyc("R6 array grant", 1, 8'h0B, 3'b100);
        idle(CYC - 1);
        cyc("R9 latch clears", 1, 8'h08, 3'b000);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule